// File: doc/BRIEF.md
# ADC Serial Data Output Port

This block is the device-side read-out path of a small multi-channel converter. When the conversion engine finishes, it strobes `conv_done` with one signed result per channel. Results can be wider than 16 bits. The port clips each result to the 16-bit two's complement range and holds the clipped set for the host. It then pulls the active-low ready flag `drdy_n` low.

The host reads a frame by taking `cs_n` low and toggling `sclk`. Each frame starts with a 24-bit status word and is followed by one 16-bit word per channel, channel 0 first. All bits go out most significant first. `cs_n` and `sclk` come from outside the device clock domain, so both pass through two-flop synchronisers before their edges are used. Raising `cs_n` drops the transfer at once and releases the data line. A conversion that finishes during a read is held back until the read ends.

Top module: `adc_sout_port`

## Requirements
- R1: A result above +32767 is sent as 16'h7FFF.
- R2: A result below -32768 is sent as 16'h8000. A result inside the range is sent unchanged as its low 16 bits.
- R3: A frame is sent MSB first, one bit per `sclk` cycle. It is 24 header bits, then channel 0 (taken from sample bits [IN_W-1:0]), then the higher channels in order. The header is 4'b1100 followed by 20 zero bits.
- R4: On the clock edge that samples `conv_done` while `drdy_n` is high, `drdy_n` goes low. This happens whatever the level of `cs_n`.
- R5: `drdy_n` stays low until the first synchronised `sclk` falling edge of a read, and then goes high.
- R6: If `conv_done` arrives while `drdy_n` is already low, `drdy_n` is high for exactly one clock and then low again.
- R7: A conversion that completes while `cs_n` is low leaves the frame in progress unchanged. The next frame carries the new results.
- R8: While the synchronised `cs_n` is high, `dout_oe` and `dout` are 0. The bit position returns to the start, so the next read begins again at header bit 23.
- R9: `dout_oe` rises two clock edges after the edge that first samples `cs_n` low.
- R10: Once all frame bits have been shifted, further `sclk` cycles read 0.
- R11: After reset, `drdy_n` is high, `dout_oe` is low, and a read returns the header followed by all-zero channel words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: new results are present on `samples` |
| samples | input | NUM_CH*IN_W | Signed results; channel i at bits [i*IN_W +: IN_W] |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| dout | output | 1 | Serial data; 0 while not enabled |
| dout_oe | output | 1 | Enable for the external tri-state buffer on the data pin |
| drdy_n | output | 1 | Active-low new-data flag |

## Verification
The hardest case to reach from the pins is a conversion that lands in the middle of a read. It must change neither the bits still to come nor the frame order, yet it must still produce a fresh `drdy_n` edge. The read task can fire `conv_done` at a chosen bit index inside an open frame. The bench checks that the rest of that frame keeps the old words and that the next frame carries the new ones. A sweep of clip boundaries, aborted reads, and back-to-back conversions while the flag is low covers the remaining corners.

// File: rtl/sout_pkg.sv
package sout_pkg;
    localparam int SAMP_W = 16;
    localparam int HDR_W  = 24;

    typedef logic signed [SAMP_W-1:0] samp_t;

    localparam logic [HDR_W-1:0] HDR_WORD = {4'b1100, {(HDR_W-4){1'b0}}};

    typedef struct packed {
        logic active;      // chip select asserted after synchronisation
        logic sclk_fall;   // synchronised falling edge while active
        logic first_fall;  // falling edge on bit 0 of a frame
    } spi_ev_t;

    function automatic samp_t clip16(input logic signed [31:0] v);
        logic signed [31:0] hi;
        logic signed [31:0] lo;
        hi = (32'sd1 <<< (SAMP_W-1)) - 32'sd1;
        lo = -(32'sd1 <<< (SAMP_W-1));
        if (v > hi)      return samp_t'(hi);
        else if (v < lo) return samp_t'(lo);
        else             return samp_t'(v);
    endfunction
endpackage

// File: rtl/sout_sync.sv
module sout_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        logic stab;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= RST_VAL[i];
                stab <= RST_VAL[i];
            end else begin
                meta <= d[i];
                stab <= meta;
            end
        end
        assign q[i] = stab;
    end
endmodule

// File: rtl/sout_sat.sv
module sout_sat
    import sout_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int IN_W   = 24,
    localparam int DATA_W = NUM_CH * SAMP_W
) (
    input  logic [NUM_CH*IN_W-1:0] raw,
    output logic [DATA_W-1:0]      sat
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic signed [31:0] ext;
        assign ext = 32'($signed(raw[i*IN_W +: IN_W]));
        assign sat[(NUM_CH-1-i)*SAMP_W +: SAMP_W] = clip16(ext);
    end
endmodule

// File: rtl/adc_sout_port.sv
module adc_sout_port
    import sout_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int IN_W   = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   conv_done,
    input  logic [NUM_CH*IN_W-1:0] samples,
    input  logic                   cs_n,
    input  logic                   sclk,
    output logic                   dout,
    output logic                   dout_oe,
    output logic                   drdy_n
);
    localparam int DATA_W  = NUM_CH * SAMP_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [1:0]        sync_q;
    logic              sclk_s;
    logic              cs_s;
    logic              sclk_q;
    spi_ev_t           ev;
    logic [DATA_W-1:0] sat_now;
    logic [DATA_W-1:0] dat;
    logic [DATA_W-1:0] dat_nxt;
    logic [DATA_W-1:0] shadow;
    logic              pend;
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              drdy_r;
    logic              rearm;

    sout_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk, cs_n}),
        .q   (sync_q)
    );
    assign sclk_s = sync_q[1];
    assign cs_s   = sync_q[0];

    sout_sat #(.NUM_CH(NUM_CH), .IN_W(IN_W)) u_sat (
        .raw (samples),
        .sat (sat_now)
    );

    always_comb begin
        ev.active     = ~cs_s;
        ev.sclk_fall  = ev.active & sclk_q & ~sclk_s;
        ev.first_fall = ev.sclk_fall & (cnt == '0);
        if (conv_done)  dat_nxt = sat_now;
        else if (pend)  dat_nxt = shadow;
        else            dat_nxt = dat;
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            dat    <= '0;
            shadow <= '0;
            pend   <= 1'b0;
            sh     <= {HDR_WORD, {DATA_W{1'b0}}};
            cnt    <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (!ev.active) begin
                dat  <= dat_nxt;
                pend <= 1'b0;
                sh   <= {HDR_WORD, dat_nxt};
                cnt  <= '0;
            end else begin
                if (conv_done) begin
                    shadow <= sat_now;
                    pend   <= 1'b1;
                end
                if (ev.sclk_fall) begin
                    sh <= {sh[FRAME_W-2:0], 1'b0};
                    if (cnt != CNT_W'(FRAME_W)) cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // ready flag
    always_ff @(posedge clk) begin
        if (rst) begin
            drdy_r <= 1'b1;
            rearm  <= 1'b0;
        end else if (conv_done) begin
            if (drdy_r) begin
                drdy_r <= 1'b0;
                rearm  <= 1'b0;
            end else begin
                drdy_r <= 1'b1;
                rearm  <= 1'b1;
            end
        end else if (rearm) begin
            drdy_r <= 1'b0;
            rearm  <= 1'b0;
        end else if (ev.first_fall) begin
            drdy_r <= 1'b1;
        end
    end

    assign dout    = ev.active & sh[FRAME_W-1];
    assign dout_oe = ev.active;
    assign drdy_n  = drdy_r;
endmodule

// File: rtl/adc_sout_port_chk.sv
module adc_sout_port_chk #(
    parameter int FRAME_W = 56,
    parameter int CNT_W   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             conv_done,
    input logic             cs_n,
    input logic             dout,
    input logic             dout_oe,
    input logic             drdy_n,
    input logic [CNT_W-1:0] cnt
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    a_r4_drdy_falls: assert property (@(posedge clk) disable iff (rst)
        conv_done && drdy_n |=> !drdy_n);

    a_r6_drdy_pulse: assert property (@(posedge clk) disable iff (rst)
        conv_done && !drdy_n |=> drdy_n);

    a_r6_drdy_relow: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !drdy_n) ##1 !conv_done |=> !drdy_n);

    a_r9_oe_lag: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (dout_oe == !$past(cs_n, 2)));

    a_r8_quiet_line: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> !dout);

    a_r8_pos_reset: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0) && !$past(dout_oe) && !dout_oe |-> (cnt == '0));

    a_r10_tail_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(FRAME_W)) |-> !dout);
endmodule

bind adc_sout_port adc_sout_port_chk #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_done (conv_done),
    .cs_n      (cs_n),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .drdy_n    (drdy_n),
    .cnt       (cnt)
);

// File: tb/adc_sout_port_tb.sv
module adc_sout_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 2;
    localparam int IN_W   = 24;
    localparam int HALF   = 8;
    localparam int NBITS  = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv_done = 1'b0;
    logic [NUM_CH*IN_W-1:0] samples = '0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic dout, dout_oe, drdy_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_sout_port #(.NUM_CH(NUM_CH), .IN_W(IN_W)) u_dut (
        .clk(clk), .rst(rst), .conv_done(conv_done), .samples(samples),
        .cs_n(cs_n), .sclk(sclk), .dout(dout), .dout_oe(dout_oe), .drdy_n(drdy_n)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] clipv(input int v);
        if (v > 32767)       return 16'h7FFF;
        else if (v < -32768) return 16'h8000;
        else                 return v[15:0];
    endfunction

    function automatic logic [63:0] exp_frame(input int a, input int b);
        return {4'h0, 24'hC00000, clipv(a), clipv(b), 4'h0};
    endfunction

    function automatic int tv(input int j);
        case (j)
            0: return 0;          1: return 1;        2: return -1;
            3: return 32767;      4: return 32768;    5: return -32768;
            6: return -32769;     7: return 8388607;  8: return -8388608;
            9: return 100;        10: return -100;    11: return 32766;
            default: return -8388608 + (j-12)*599185;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_conv(input int a, input int b);
        samples   = {b[IN_W-1:0], a[IN_W-1:0]};
        conv_done = 1'b1;
        tick(1);
        conv_done = 1'b0;
    endtask

    // nbits read; if mid_at >= 0, a conversion (na, nb) fires during that bit
    task automatic read_frame(input int nbits, input int mid_at, input int na, input int nb,
                              input bit chk_oe, output logic [63:0] bits);
        bits = '0;
        cs_n = 1'b0;
        tick(1);
        if (chk_oe) chk(dout_oe == 1'b0, "R9 oe low after one edge", 64'(dout_oe), 0);
        tick(1);
        if (chk_oe) chk(dout_oe == 1'b1, "R9 oe high after two edges", 64'(dout_oe), 1);
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            if (i == mid_at) pulse_conv(na, nb); else tick(1);
            tick(HALF-1);
            bits = {bits[62:0], dout};
            sclk = 1'b0;
            tick(HALF);
        end
    endtask

    task automatic end_read();
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic cmp_frame(input logic [63:0] got, input logic [63:0] exp, input string tag);
        chk(got[59:36] == exp[59:36], {tag, " R3 header"}, 64'(got[59:36]), 64'(exp[59:36]));
        chk(got[35:20] == exp[35:20], {tag, " R1/R2 ch0"}, 64'(got[35:20]), 64'(exp[35:20]));
        chk(got[19:4]  == exp[19:4],  {tag, " R1/R2 ch1"}, 64'(got[19:4]),  64'(exp[19:4]));
        chk(got[3:0]   == 4'h0,       {tag, " R10 tail"},  64'(got[3:0]),   0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] f;
        tick(4);
        rst = 1'b0;
        tick(2);
        // R11 reset state
        chk(drdy_n == 1'b1, "R11 drdy after reset", 64'(drdy_n), 1);
        chk(dout_oe == 1'b0, "R11 oe after reset", 64'(dout_oe), 0);
        read_frame(NBITS, -1, 0, 0, 1'b1, f);
        end_read();
        cmp_frame(f, exp_frame(0, 0), "R11 reset");
        chk(drdy_n == 1'b1, "R11 drdy stays high", 64'(drdy_n), 1);

        // sweep clip boundaries and the full input range
        for (int j = 0; j < 40; j++) begin
            int a;
            int b;
            a = tv(j);
            b = tv(39 - j);
            pulse_conv(a, b);
            chk(drdy_n == 1'b0, "R4 drdy low after conversion", 64'(drdy_n), 0);
            tick(3);
            read_frame(NBITS, -1, 0, 0, 1'b0, f);
            chk(drdy_n == 1'b1, "R5 drdy high after read", 64'(drdy_n), 1);
            end_read();
            cmp_frame(f, exp_frame(a, b), "sweep");
        end

        // R5: flag holds until first falling edge
        pulse_conv(5, 6);
        cs_n = 1'b0;
        tick(6);
        sclk = 1'b1;
        tick(HALF);
        chk(drdy_n == 1'b0, "R5 drdy low before first fall", 64'(drdy_n), 0);
        sclk = 1'b0;
        tick(HALF);
        chk(drdy_n == 1'b1, "R5 drdy high after first fall", 64'(drdy_n), 1);
        end_read();

        // R6: second conversion while flag low
        pulse_conv(7, 8);
        chk(drdy_n == 1'b0, "R6 drdy low first", 64'(drdy_n), 0);
        tick(2);
        pulse_conv(9, 10);
        chk(drdy_n == 1'b1, "R6 drdy pulse high", 64'(drdy_n), 1);
        tick(1);
        chk(drdy_n == 1'b0, "R6 drdy low again", 64'(drdy_n), 0);
        read_frame(NBITS, -1, 0, 0, 1'b0, f);
        end_read();
        cmp_frame(f, exp_frame(9, 10), "R6 latest");

        // R7: conversion during a transfer; R4 while cs low
        pulse_conv(1234, -1234);
        tick(3);
        read_frame(NBITS, 20, 40000, -40000, 1'b0, f);
        chk(drdy_n == 1'b0, "R4 drdy low with cs low", 64'(drdy_n), 0);
        end_read();
        cmp_frame(f, exp_frame(1234, -1234), "R7 frame kept");
        read_frame(NBITS, -1, 0, 0, 1'b0, f);
        end_read();
        cmp_frame(f, exp_frame(40000, -40000), "R7 next frame");

        // R8: abort mid-frame, then restart from header
        pulse_conv(-5, 300);
        tick(3);
        read_frame(10, -1, 0, 0, 1'b0, f);
        cs_n = 1'b1;
        tick(3);
        chk(dout_oe == 1'b0, "R8 oe low after abort", 64'(dout_oe), 0);
        chk(dout == 1'b0, "R8 dout low after abort", 64'(dout), 0);
        tick(3);
        read_frame(NBITS, -1, 0, 0, 1'b0, f);
        end_read();
        cmp_frame(f, exp_frame(-5, 300), "R8 restart");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule